// File: doc/BRIEF.md
# Polyphase Channeliser Weighting Stage

This block is the windowed FIR stage that sits in front of a P-point FFT in a critically sampled polyphase filter bank. Real two's-complement samples in the range [-1, 1) arrive as vectors of P samples. A sync pulse marks the vector phase: the first sample accepted after the pulse is position 0. For every accepted sample at position k, the block forms a weighted sum over T taps. Tap 0 is the sample itself. Tap t is the sample at the same position k from t vectors earlier. Tap t is weighted by coefficient h[t*P + k] from a window table that is computed at elaboration. The result is rounded and saturated to the output width. The stream of such sums is the input that turns each downstream FFT bin into a shaped channel filter. In effect the block is P interleaved decimating subfilters that share T-1 delay memories, one per older tap, each P words deep.

Both sides use a valid/ready handshake. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Holding `out_ready` low therefore stalls the input with no loss. While stalled, the pending output stays frozen. The output carries sidebands:
- `out_start` marks position 0 of each vector. It takes the place of the input's sync pulse, so the FFT downstream stays phased however long the pipeline is.
- `out_settled` reports whether the tap memories hold real history yet.
- `out_ovf` reports clipping.

Top module: `pfb_fir_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is low. All T-1 tap delay memories start at zero after reset.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_start`, `out_settled` and `out_ovf` stay unchanged on the next cycle.
- R3: After a cycle with `in_sync` high, the next accepted beat takes position 0 and its output has `out_start` = 1. A beat accepted in the same cycle as the pulse still belongs to the old phase. Each later used beat takes position (previous + 1) mod P. A new pulse restarts the count at any point.
- R4: Beats accepted before the first sync pulse after reset produce no output. They leave the tap memories untouched.
- R5: For a used beat x at position k, the output is y = sat(floor((S + 2^(SH-1)) / 2^SH)). Here S = sum over t = 0..T-1 of h[t*P+k] times (x when t = 0, else the position-k sample from t vectors earlier), and SH = IW + CW - 1 - OW.
- R6: The window is selected by parameter WIN, with L = T*P and CMAX = 2^(CW-1) - 1. WIN = 0 gives a flat window, h[i] = floor(CMAX / T). WIN = 1 gives a triangular window, h[i] = floor(CMAX * min(i+1, L-i) / (L/2)).
- R7: Saturation clips to [-2^(OW-1), 2^(OW-1)-1]. `out_ovf` is 1 exactly when the rounded sum lies outside that range.
- R8: The block counts position-0 beats since reset, including the current one. `out_settled` is 0 while that count is below T and 1 from then on.
- R9: A used beat accepted on a clock edge is presented with `out_valid` high right after that same edge.
- R10: Until T vectors have passed, the older taps contribute zero (the reset contents of the delay memories) to the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept an input beat |
| in_data | input | IW | Input sample, two's complement, IW-1 fraction bits |
| in_sync | input | 1 | Pulse: the next accepted beat is vector position 0 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | OW | Weighted sum, two's complement, OW-1 fraction bits |
| out_start | output | 1 | Output beat is vector position 0 |
| out_settled | output | 1 | All T taps hold samples received since reset |
| out_ovf | output | 1 | Output beat was clipped |

## Verification
A wrong word in one delay memory does not show at once. It appears in `out_data` only when that same position comes round again, one vector (P used beats) later. It then keeps moving to deeper taps for up to T-1 more vectors. A slip in the position counter shows on the next output as a wrong `out_start` and a wrong coefficient choice. An error in the vector counter stays hidden until the T-th position-0 beat, where `out_settled` rises. The bench therefore runs more than T vectors after each sync pulse. It also drives full-scale runs of both signs, so that the rounding offset and both clip limits are reached.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  typedef enum int {
    WIN_FLAT = 0,
    WIN_TRI  = 1
  } win_kind_e;

  // Sideband carried with every output beat.
  typedef struct packed {
    logic start;
    logic settled;
    logic ovf;
  } beat_tag_t;

  // Window coefficient for flat index i of a table of taps*pts entries.
  function automatic int coef_val(input int i, input int taps, input int pts,
                                  input int cw, input int kind);
    int cmax;
    int len;
    int m;
    cmax = (1 << (cw - 1)) - 1;
    len  = taps * pts;
    if (kind == int'(WIN_FLAT)) begin
      return cmax / taps;
    end
    m = ((i + 1) < (len - i)) ? (i + 1) : (len - i);
    return (cmax * m) / (len / 2);
  endfunction

endpackage

// File: rtl/pfb_phase_ctrl.sv
module pfb_phase_ctrl #(
  parameter int PTS  = 16,
  parameter int TAPS = 4,
  localparam int IDXW = $clog2(PTS),
  localparam int CNTW = $clog2(TAPS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic            beat_i,
  output logic            pend_o,
  output logic            use_o,
  output logic [IDXW-1:0] idx_o,
  output logic            start_o,
  output logic            settled_o
);

  logic            pend_q;
  logic            locked_q;
  logic [IDXW-1:0] idx_q;
  logic [CNTW-1:0] starts_q;
  logic [CNTW:0]   cnt_now;

  assign pend_o  = pend_q;
  assign use_o   = pend_q | locked_q;
  assign idx_o   = pend_q ? '0 : (idx_q + IDXW'(1));
  assign start_o = use_o && (idx_o == '0);
  assign cnt_now = {1'b0, starts_q} + (CNTW + 1)'(start_o);
  assign settled_o = cnt_now >= (CNTW + 1)'(TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
      idx_q    <= '0;
      starts_q <= '0;
    end else begin
      pend_q <= sync_i | (pend_q & ~beat_i);
      if (beat_i && use_o) begin
        idx_q    <= idx_o;
        locked_q <= 1'b1;
        if (start_o && (starts_q != CNTW'(TAPS))) begin
          starts_q <= starts_q + CNTW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pfb_tap_store.sv
module pfb_tap_store #(
  parameter int PTS  = 16,
  parameter int TAPS = 4,
  parameter int IW   = 12,
  localparam int IDXW = $clog2(PTS),
  localparam int OLD  = TAPS - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [IDXW-1:0]        idx_i,
  input  logic signed [IW-1:0]   x_i,
  output logic signed [IW-1:0]   old_o [OLD]
);

  // mem[j][k]: sample at position k from j+1 vectors ago.
  logic signed [IW-1:0] mem [OLD][PTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < OLD; j++) begin
        for (int k = 0; k < PTS; k++) begin
          mem[j][k] <= '0;
        end
      end
    end else if (wr_i) begin
      mem[0][idx_i] <= x_i;
      for (int j = 1; j < OLD; j++) begin
        mem[j][idx_i] <= mem[j-1][idx_i];
      end
    end
  end

  always_comb begin
    for (int j = 0; j < OLD; j++) begin
      old_o[j] = mem[j][idx_i];
    end
  end

endmodule

// File: rtl/pfb_mac.sv
module pfb_mac #(
  parameter int PTS  = 16,
  parameter int TAPS = 4,
  parameter int IW   = 12,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int WIN  = 1,
  localparam int IDXW = $clog2(PTS),
  localparam int PW   = IW + CW,
  localparam int SW   = PW + $clog2(TAPS) + 1,
  localparam int SH   = IW + CW - 1 - OW
) (
  input  logic [IDXW-1:0]        idx_i,
  input  logic signed [IW-1:0]   tap_i [TAPS],
  output logic signed [OW-1:0]   y_o,
  output logic                   ovf_o
);

  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (SH - 1);
  localparam logic signed [SW-1:0] OMAX = SW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] OMIN = -(SW'(64'sd1 <<< (OW - 1)));

  logic signed [CW-1:0] rom [TAPS][PTS];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    for (genvar k = 0; k < PTS; k++) begin : g_pos
      assign rom[t][k] = CW'(pfb_pkg::coef_val(t * PTS + k, TAPS, PTS, CW, WIN));
    end
  end

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] rnd;
  logic signed [PW-1:0] prod;

  always_comb begin
    acc  = '0;
    prod = '0;
    for (int t = 0; t < TAPS; t++) begin
      prod = PW'(tap_i[t]) * PW'(rom[t][idx_i]);
      acc  = acc + SW'(prod);
    end
    rnd = (acc + HALF) >>> SH;
    if (rnd > OMAX) begin
      y_o   = OW'(OMAX);
      ovf_o = 1'b1;
    end else if (rnd < OMIN) begin
      y_o   = OW'(OMIN);
      ovf_o = 1'b1;
    end else begin
      y_o   = OW'(rnd);
      ovf_o = 1'b0;
    end
  end

endmodule

// File: rtl/pfb_fir_front.sv
module pfb_fir_front #(
  parameter int PTS  = 16,
  parameter int TAPS = 4,
  parameter int IW   = 12,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int WIN  = 1,
  localparam int IDXW = $clog2(PTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IW-1:0]        in_data,
  input  logic                 in_sync,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OW-1:0]        out_data,
  output logic                 out_start,
  output logic                 out_settled,
  output logic                 out_ovf
);

  import pfb_pkg::*;

  logic            beat;
  logic            pend;
  logic            use_beat;
  logic [IDXW-1:0] idx;
  logic            start;
  logic            settled;

  logic signed [IW-1:0] taps   [TAPS];
  logic signed [IW-1:0] older  [TAPS-1];
  logic signed [OW-1:0] y;
  logic                 ovf;
  beat_tag_t            tag_d;
  beat_tag_t            tag_q;

  assign in_ready = !out_valid || out_ready;
  assign beat     = in_valid && in_ready;

  pfb_phase_ctrl #(.PTS(PTS), .TAPS(TAPS)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_i   (in_sync),
    .beat_i   (beat),
    .pend_o   (pend),
    .use_o    (use_beat),
    .idx_o    (idx),
    .start_o  (start),
    .settled_o(settled)
  );

  pfb_tap_store #(.PTS(PTS), .TAPS(TAPS), .IW(IW)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_i (beat && use_beat),
    .idx_i(idx),
    .x_i  (in_data),
    .old_o(older)
  );

  always_comb begin
    taps[0] = in_data;
    for (int t = 1; t < TAPS; t++) begin
      taps[t] = older[t-1];
    end
  end

  pfb_mac #(.PTS(PTS), .TAPS(TAPS), .IW(IW), .CW(CW), .OW(OW), .WIN(WIN)) u_mac (
    .idx_i(idx),
    .tap_i(taps),
    .y_o  (y),
    .ovf_o(ovf)
  );

  assign tag_d = '{start: start, settled: settled, ovf: ovf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      tag_q     <= '0;
    end else if (beat && use_beat) begin
      out_valid <= 1'b1;
      out_data  <= y;
      tag_q     <= tag_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_start   = tag_q.start;
  assign out_settled = tag_q.settled;
  assign out_ovf     = tag_q.ovf;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(tag_q)); // R2

  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    beat && pend |=> out_valid && out_start); // R3

  AST_DROP_UNPHASED: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !use_beat |=> !out_valid); // R4

  AST_CLIP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> (out_data == {1'b0, {(OW-1){1'b1}}}) || (out_data == {1'b1, {(OW-1){1'b0}}})); // R7

  AST_SETTLED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_settled |=> !out_valid || out_settled); // R8

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    beat && use_beat |=> out_valid); // R9

endmodule

// File: tb/pfb_fir_front_bench.sv
module pfb_fir_front_bench;

  localparam int PTS  = 16;
  localparam int TAPS = 4;
  localparam int IW   = 12;
  localparam int CW   = 16;
  localparam int OW   = 16;
  localparam int WIN  = 1;
  localparam int SH   = IW + CW - 1 - OW;
  localparam int NCYC = 760;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [IW-1:0] in_data;
  logic          in_sync;
  logic          out_valid;
  logic          out_ready;
  logic [OW-1:0] out_data;
  logic          out_start;
  logic          out_settled;
  logic          out_ovf;

  pfb_fir_front #(.PTS(PTS), .TAPS(TAPS), .IW(IW), .CW(CW), .OW(OW), .WIN(WIN)) u_pfb_fir_front (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sync(in_sync),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_start(out_start), .out_settled(out_settled), .out_ovf(out_ovf)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference state
  longint hist [TAPS-1][PTS];
  bit     m_valid, m_start, m_settled, m_ovf, m_pend, m_lock;
  longint m_data;
  int     m_idx, m_starts;
  int unsigned rs = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Window table per R6
  function automatic longint coef(input int i);
    longint cmax;
    longint len;
    longint m;
    cmax = (longint'(1) <<< (CW - 1)) - 1;
    len  = TAPS * PTS;
    if (WIN == 0) return cmax / TAPS;
    m = ((i + 1) < (len - i)) ? (i + 1) : (len - i);
    return (cmax * m) / (len / 2);
  endfunction

  function automatic int unsigned nxt(input int unsigned s);
    int unsigned x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic model_reset();
    for (int j = 0; j < TAPS - 1; j++)
      for (int k = 0; k < PTS; k++) hist[j][k] = 0;   // R10 zero history
    m_valid = 0; m_start = 0; m_settled = 0; m_ovf = 0;
    m_pend = 0; m_lock = 0; m_data = 0; m_idx = 0; m_starts = 0;
  endtask

  task automatic model_step(input bit v, input bit s, input int d, input bit ordy);
    bit     acc;
    int     k;
    longint sum;
    longint r;
    longint omax;
    longint omin;
    omax = (longint'(1) <<< (OW - 1)) - 1;
    omin = -(longint'(1) <<< (OW - 1));
    acc = v && (!m_valid || ordy);
    if (acc) begin
      if (m_pend || m_lock) begin
        k = m_pend ? 0 : (m_idx + 1) % PTS;
        sum = coef(k) * d;
        for (int t = 1; t < TAPS; t++) sum += coef(t * PTS + k) * hist[t-1][k];
        for (int j = TAPS - 2; j >= 1; j--) hist[j][k] = hist[j-1][k];
        hist[0][k] = d;
        r = (sum + (longint'(1) <<< (SH - 1))) >>> SH;
        m_ovf = 0;
        if (r > omax) begin r = omax; m_ovf = 1; end
        if (r < omin) begin r = omin; m_ovf = 1; end
        m_data  = r;
        m_start = (k == 0);
        if (k == 0) m_starts++;
        m_settled = (m_starts >= TAPS);
        m_valid = 1;
        m_idx   = k;
        m_lock  = 1;
      end else begin
        m_valid = 0;
      end
    end else if (ordy) begin
      m_valid = 0;
    end
    m_pend = s || (m_pend && !acc);
  endtask

  initial begin
    bit v, s, ordy;
    int d;
    rst_n = 0; in_valid = 0; in_sync = 0; in_data = '0; out_ready = 0;
    model_reset();
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      // Registered outputs against the reference
      chk(out_valid == m_valid, (c < 20) ? "R4 R1 out_valid" : "R9 out_valid",
          longint'(out_valid), longint'(m_valid));
      if (m_valid && out_valid) begin
        chk(longint'($signed(out_data)) == m_data, "R5 R6 R10 out_data",
            longint'($signed(out_data)), m_data);
        chk(out_start == m_start, "R3 out_start", longint'(out_start), longint'(m_start));
        chk(out_settled == m_settled, "R8 out_settled", longint'(out_settled), longint'(m_settled));
        chk(out_ovf == m_ovf, "R7 out_ovf", longint'(out_ovf), longint'(m_ovf));
      end
      // Stimulus
      rs = nxt(rs);
      s = 0; v = 0; ordy = 1; d = int'(rs % 4096) - 2048;
      if (c < 4) begin
        v = 0; ordy = 0;
      end else if (c < 19) begin
        v = 1;                                  // R4: no sync yet
      end else if (c == 19) begin
        s = 1;
      end else if (c < 260) begin
        v = ((rs >> 8) % 5) != 0;
        ordy = (c % 7) != 3;                    // R2 stalls
        if (c == 200) begin v = 1; s = 1; end   // R3 sync with a beat
      end else if (c < 420) begin
        v = 1; d = 2047;                        // R7 high clip
      end else if (c < 560) begin
        v = 1; d = -2048;                       // R7 low clip
      end else begin
        v = ((rs >> 8) % 4) != 0;
        ordy = (c % 20) < 15;
        if (c == 600) s = 1;
      end
      rst_n = (c >= 4);
      in_valid = v; in_sync = s; in_data = IW'(d); out_ready = ordy;
      #1;
      chk(in_ready == (!m_valid || ordy), "R2 in_ready", longint'(in_ready),
          longint'(!m_valid || ordy));
      if (rst_n) model_step(v, s, d, ordy);
      else model_reset();                       // R1
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule